// File: doc/BRIEF.md
# Full-Rate Cascaded Integrator-Comb Filter with Sine Compensation

This block is a fifth-order cascaded integrator-comb low-pass filter that never decimates. Every stage runs once per accepted input sample, and each comb compares its input against a 28-sample delay line instead of a rate-reduced neighbour. The filter is followed by a sparse three-tap compensator. Its taps sit at delays 0, R and 2R, and it lifts the droop of the comb response near the corner frequency.

Signed samples enter with a valid strobe, and filtered signed samples leave at the same rate after a fixed latency. The compensator gain is a run-time power of two, Δ = 2^-k, chosen so the passband does not overshoot. All Δ and Δ/2 products are arithmetic right shifts, so there is no multiplier. Internal registers are 25 bits wider than the input and wrap in two's complement. Because the comb differences remove the wrap, the integrators need no saturation.

Top module: `cicsc_filter`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` and `out_data` are 0 and all integrator, comb and delay state is zero, so a stream of zero samples yields zero outputs.
- R2: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and low otherwise.
- R3: In a cycle with `in_valid` low, no internal state changes and `out_data` holds its value. The stream resumes as if the idle cycles had not occurred.
- R4: The output produced for input sample n is y[n-10], a latency of ten accepted samples. The outputs for the first ten samples after reset are 0.
- R5: The filter core is five integrators 1/(1-z^-1) followed by five combs 1-z^-28. Each comb runs on every sample (M=1), and the impulse response is the five-fold convolution of a 28-sample boxcar.
- R6: With c[n] the filter core output and k the value of `shift_k` (unsigned, 3 bits, k = 0..7, Δ = 2^-k), the output is y[n] = c[n-28] + (c[n-28] >>> k) - (c[n] >>> (k+1)) - (c[n-56] >>> (k+1)). Here >>> is an arithmetic shift and terms before sample 0 are 0.
- R7: For a constant input x held long enough to fill all delays, the output settles at exactly x·28^5 for every k.
- R8: Integrators wrap in two's complement without saturation. A full-scale negative step (-32768) still settles exactly at -32768·28^5.
- R9: A random input stream with random idle gaps is reproduced bit-exactly according to R4 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| shift_k | input | 3 | Compensator gain exponent, Δ = 2^-k |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 43 | Signed filtered sample |

## Verification
The assertions check the timing on every cycle. They confirm that `out_valid` follows `in_valid` by exactly one cycle, and that neither the filter core output nor `out_data` moves in a cycle without a sample. The numerical behaviour is checked only by the bench scenarios, which compare every output against an unpipelined integer model. These scenarios cover the ten-sample latency, the boxcar impulse shape, the compensator shift arithmetic for several k, the exact DC gain and the wraparound on a full-scale negative step.

// File: rtl/cicsc_pkg.sv
package cicsc_pkg;
  // Bits of growth a CIC core needs: order times ceil(log2(rate)).
  function automatic int growth_bits(input int order, input int rate);
    return order * $clog2(rate);
  endfunction
endpackage

// File: rtl/cicsc_integ_chain.sv
module cicsc_integ_chain #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 41,
  parameter int ORDER  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [ACC_W-1:0]  acc_out
);
  logic [ACC_W-1:0] acc_q [ORDER];
  logic [ACC_W-1:0] acc_d [ORDER];

  for (genvar i = 0; i < ORDER; i++) begin : g_stage
    logic [ACC_W-1:0] src;
    if (i == 0) begin : g_first
      assign src = ACC_W'($signed(din));
    end else begin : g_next
      assign src = acc_q[i-1];
    end

    always_comb begin
      acc_d[i] = acc_q[i] + src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[i] <= '0;
      end else if (en) begin
        acc_q[i] <= acc_d[i];
      end
    end
  end

  assign acc_out = acc_q[ORDER-1];
endmodule

// File: rtl/cicsc_comb_chain.sv
module cicsc_comb_chain #(
  parameter int ACC_W = 41,
  parameter int ORDER = 5,
  parameter int RATE  = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] din,
  output logic [ACC_W-1:0] dout
);
  logic [ACC_W-1:0] diff_q [ORDER];

  for (genvar j = 0; j < ORDER; j++) begin : g_stage
    logic [ACC_W-1:0] s_in;
    logic [ACC_W-1:0] diff_d;
    logic [ACC_W-1:0] line_q [RATE];

    if (j == 0) begin : g_first
      assign s_in = din;
    end else begin : g_next
      assign s_in = diff_q[j-1];
    end

    always_comb begin
      diff_d = s_in - line_q[RATE-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        diff_q[j] <= '0;
        for (int t = 0; t < RATE; t++) line_q[t] <= '0;
      end else if (en) begin
        diff_q[j] <= diff_d;
        line_q[0] <= s_in;
        for (int t = 1; t < RATE; t++) line_q[t] <= line_q[t-1];
      end
    end
  end

  assign dout = diff_q[ORDER-1];
endmodule

// File: rtl/cicsc_sine_comp.sv
module cicsc_sine_comp #(
  parameter int ACC_W   = 41,
  parameter int OUT_W   = 43,
  parameter int RATE    = 28,
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [ACC_W-1:0]   din,
  input  logic [SHIFT_W-1:0] shift_k,
  output logic [OUT_W-1:0]   dout
);
  localparam int DEPTH = 2 * RATE;

  logic [ACC_W-1:0]   line_q [DEPTH];
  logic [SHIFT_W:0]   half_k;
  logic signed [OUT_W-1:0] t_now, t_mid, t_far, sum_d;
  logic [OUT_W-1:0]   dout_q;

  always_comb begin
    half_k = {1'b0, shift_k} + 1'b1;
    t_now  = OUT_W'($signed(din));
    t_mid  = OUT_W'($signed(line_q[RATE-1]));
    t_far  = OUT_W'($signed(line_q[DEPTH-1]));
    sum_d  = t_mid + (t_mid >>> shift_k) - (t_now >>> half_k) - (t_far >>> half_k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      for (int t = 0; t < DEPTH; t++) line_q[t] <= '0;
    end else if (en) begin
      dout_q    <= sum_d;
      line_q[0] <= din;
      for (int t = 1; t < DEPTH; t++) line_q[t] <= line_q[t-1];
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/cicsc_filter.sv
module cicsc_filter #(
  parameter int DATA_W  = 16,
  parameter int ORDER   = 5,
  parameter int RATE    = 28,
  parameter int SHIFT_W = 3,
  localparam int ACC_W  = DATA_W + cicsc_pkg::growth_bits(ORDER, RATE),
  localparam int OUT_W  = ACC_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [SHIFT_W-1:0] shift_k,
  output logic               out_valid,
  output logic [OUT_W-1:0]   out_data
);
  logic [ACC_W-1:0] integ_out;
  logic [ACC_W-1:0] cic_q;
  logic             valid_q;

  cicsc_integ_chain #(.DATA_W(DATA_W), .ACC_W(ACC_W), .ORDER(ORDER)) u_integ (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .din(in_data), .acc_out(integ_out)
  );

  cicsc_comb_chain #(.ACC_W(ACC_W), .ORDER(ORDER), .RATE(RATE)) u_comb (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .din(integ_out), .dout(cic_q)
  );

  cicsc_sine_comp #(.ACC_W(ACC_W), .OUT_W(OUT_W), .RATE(RATE), .SHIFT_W(SHIFT_W)) u_comp (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .din(cic_q), .shift_k(shift_k), .dout(out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
    end
  end

  assign out_valid = valid_q;
endmodule

// File: rtl/cicsc_filter_chk.sv
module cicsc_filter_chk #(
  parameter int ACC_W = 41,
  parameter int OUT_W = 43
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic [ACC_W-1:0] cic_out
);
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  assert_hold_cic_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cic_out));
endmodule

bind cicsc_filter cicsc_filter_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_data(out_data), .cic_out(cic_q)
);

// File: tb/cicsc_filter_bench.sv
module cicsc_filter_bench;
  localparam int R   = 28;
  localparam int LAT = 10;
  localparam int NM  = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic [2:0]  shift_k;
  logic        out_valid;
  logic [42:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cicsc_filter u_cicsc_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .shift_k(shift_k), .out_valid(out_valid), .out_data(out_data)
  );

  // Unpipelined integer model of the requirements.
  longint acc [5];
  longint cm [6][NM];
  longint ym [NM];
  int     n_idx;
  int     kk;

  task automatic model_clear();
    for (int i = 0; i < 5; i++) acc[i] = 0;
    n_idx = 0;
  endtask

  task automatic model_push(input longint x);
    longint v0, v1, v2;
    acc[0] += x;
    for (int i = 1; i < 5; i++) acc[i] += acc[i-1];
    cm[0][n_idx] = acc[4];
    for (int j = 1; j < 6; j++)
      cm[j][n_idx] = cm[j-1][n_idx] - ((n_idx >= R) ? cm[j-1][n_idx-R] : 64'sd0);
    v0 = cm[5][n_idx];
    v1 = (n_idx >= R)   ? cm[5][n_idx-R]   : 64'sd0;
    v2 = (n_idx >= 2*R) ? cm[5][n_idx-2*R] : 64'sd0;
    ym[n_idx] = v1 + (v1 >>> kk) - (v0 >>> (kk+1)) - (v2 >>> (kk+1));
    n_idx++;
  endtask

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (sample %0d)", req, act, exp, n_idx);
    end
  endtask

  task automatic do_reset(input int k);
    kk = k;
    shift_k = 3'(k);
    in_valid = 1'b0;
    in_data = '0;
    rst_n = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Send one sample; check the output it produces and any idle cycles after it.
  task automatic send(input int x, input int gap, input string req);
    longint act, hold;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'(x);
    model_push(longint'(x));
    @(posedge clk); #1;
    act = $signed(out_data);
    check({req, " out_valid"}, longint'(out_valid), 1);
    check(req, act, (n_idx - 1 >= LAT) ? ym[n_idx-1-LAT] : 64'sd0);
    if (gap > 0) begin
      @(negedge clk);
      in_valid = 1'b0;
      hold = act;
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1;
        check("R2 idle out_valid", longint'(out_valid), 0);
        check("R3 idle hold", longint'($signed(out_data)), hold);
      end
    end
  endtask

  task automatic t_reset();
    do_reset(0);
    #1;
    check("R1 reset out_valid", longint'(out_valid), 0);
    check("R1 reset out_data", longint'($signed(out_data)), 0);
    for (int i = 0; i < 12; i++) send(0, 0, "R1 zero stream");
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic t_impulse(input int k, input int amp);
    do_reset(k);
    send(amp, 0, "R5 impulse");
    for (int i = 1; i < 220; i++) begin
      if (i == LAT - 1) begin
        send(0, 0, "R4 before latency");
        check("R4 zero before sample 10", longint'($signed(out_data)), 0);
      end else if (i == LAT) begin
        send(0, 0, "R6 first output");
        check("R4 first nonzero", longint'($signed(out_data)),
              -(longint'(amp) >>> (k+1)));
      end else begin
        send(0, 0, "R5 impulse tail");
      end
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic t_step(input int k, input int x, input string req);
    longint gain;
    gain = 64'sd17210368; // 28**5
    do_reset(k);
    for (int i = 0; i < 260; i++) send(x, 0, req);
    check({req, " steady value"}, longint'($signed(out_data)), longint'(x) * gain);
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic t_idle();
    do_reset(3);
    for (int i = 0; i < 40; i++) send((i * 37) % 200 - 100, 0, "R3 before idle");
    send(77, 6, "R3 idle");
    for (int i = 0; i < 80; i++) send((i * 53) % 300 - 150, 0, "R3 resume");
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic t_random(input int k);
    logic [31:0] lf;
    lf = 32'hACE1_2468;
    do_reset(k);
    for (int i = 0; i < 320; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      send($signed(lf[15:0]), (lf[20:18] == 3'd0) ? int'(lf[23:22]) + 1 : 0, "R9 random");
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    shift_k = '0;
    t_reset();
    t_impulse(0, 100);
    t_impulse(4, -2345);
    t_step(2, 1234, "R7 step");
    t_step(7, -32768, "R8 wrap step");
    t_idle();
    t_random(5);
    t_random(1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule